// File: doc/BRIEF.md
# Write-Only I2C Control Register Target

This block is an I2C target that accepts write-only transfers into a small bank of 8-bit control registers. The SCL and SDA lines pass through synchronizers clocked by a fast system clock, at least 16 times the bus rate. The block detects START and STOP conditions and compares the first byte with a fixed 7-bit address plus a write bit. It acknowledges every byte it accepts by pulling SDA low.

The second byte of a transfer sets the register pointer. Each later byte is stored in the register at the pointer, and the pointer then steps to the next register, wrapping from the last register back to the first. Each stored value takes effect on the SCL rising edge that samples its last bit, before the acknowledge. At that moment a one-cycle "updated" strobe fires for the register that was written. The whole register bank is visible on the outputs at all times. An active-low power-good input clears everything.

Top module: `cfg_i2c_target`

## Requirements
- R1: While or after `pwrGoodN` is low, all registers read 0, `regUpdated` is 0 and `sdaPullLow` is 0.
- R2: A first byte of 0xE4 (address 1110010, then R/W = 0) is acknowledged: `sdaPullLow` is high during the 9th SCL clock of that byte and low again after the 9th falling edge.
- R3: A first byte with any other address, or with R/W = 1, is not acknowledged. The bytes that follow it until the next START are also not acknowledged and change no register.
- R4: The second byte is acknowledged and writes no register. Its low 2 bits become the register pointer.
- R5: Each data byte is stored in the register at the pointer, and the pointer then increments. After register 3 comes register 0. Register n occupies bits [8n+7:8n] of `regBank`.
- R6: A data byte's value appears in `regBank` after the SCL rising edge that samples its 8th bit, while SCL is still high and before `sdaPullLow` asserts. Before that edge the register still holds its old value.
- R7: A STOP returns the target to idle and leaves the registers unchanged. Clocked bytes that arrive after a STOP without a new START are ignored.
- R8: A repeated START, with no STOP before it, restarts address matching.
- R9: Any number of data bytes may follow in one transfer, and every one of them is acknowledged.
- R10: Each committed data byte raises exactly one bit of `regUpdated`, the bit of the register written, for one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| pwrGoodN | input | 1 | Active-low power-good reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaPullLow | output | 1 | High to pull SDA low (open-drain acknowledge) |
| regBank | output | 32 | Register contents; register n at bits [8n+7:8n] |
| regUpdated | output | 4 | One-cycle strobe for each register that is written |

## Verification
A table of single-byte writes covers every pointer value, including a pointer byte with upper bits set. The same table also carries a read-direction byte and a wrong address, which separates acknowledged writes from NACKed and ignored transfers. A long burst that starts at register 2 shows the pointer wrap and the unlimited byte count. In that burst the bench also samples the bank just before and just after the D0 rising edge, which pins the commit to that edge rather than to the ACK. Further directed sequences cover bytes clocked after a STOP, a repeated START that replaces a good address with a bad one and back again, and a power-good drop after registers have been loaded.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_PTR, ST_PTR_ACK, ST_DATA, ST_DATA_ACK, ST_SKIP
  } tgtState_t;

  typedef struct packed {
    logic shiftEn;  // sample current SDA into the byte shifter
    logic ptrLoad;  // last bit of the pointer byte
    logic commit;   // last bit of a data byte
  } ctrlStrobe_t;
endpackage

// File: rtl/cfg_i2c_bus_sampler.sv
module cfg_i2c_bus_sampler #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclRaw,
  input  logic sdaRaw,
  output logic sdaLevel,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  logic [SYNC_DEPTH-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_DEPTH-2:0], sclRaw};
      sdaSync <= {sdaSync[SYNC_DEPTH-2:0], sdaRaw};
      sclPrev <= sclSync[SYNC_DEPTH-1];
      sdaPrev <= sdaSync[SYNC_DEPTH-1];
    end
  end

  assign sclLevel  = sclSync[SYNC_DEPTH-1];
  assign sdaLevel  = sdaSync[SYNC_DEPTH-1];
  assign sclRise   = sclLevel & ~sclPrev;
  assign sclFall   = ~sclLevel & sclPrev;
  assign startSeen = sclLevel & sclPrev & sdaPrev & ~sdaLevel;
  assign stopSeen  = sclLevel & sclPrev & ~sdaPrev & sdaLevel;
endmodule

// File: rtl/cfg_i2c_ctrl.sv
module cfg_i2c_ctrl
  import cfg_i2c_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startSeen,
  input  logic        stopSeen,
  input  logic        addrHit,
  output ctrlStrobe_t stb,
  output logic        sdaPullLow
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  tgtState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic addrOk, inByte, lastBit;

  assign inByte  = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_DATA);
  assign lastBit = (bitCnt == LAST_BIT);

  always_comb begin
    stb.shiftEn = inByte && sclRise && (bitCnt != FULL);
    stb.ptrLoad = (state == ST_PTR)  && sclRise && lastBit;
    stb.commit  = (state == ST_DATA) && sclRise && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      addrOk <= 1'b0;
    end else if (startSeen) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopSeen) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_DATA: begin
          if (sclRise && bitCnt != FULL) begin
            bitCnt <= bitCnt + 1'b1;
            if (state == ST_ADDR && lastBit) addrOk <= addrHit;
          end
          if (sclFall && bitCnt == FULL) begin
            bitCnt <= '0;
            case (state)
              ST_ADDR: state <= addrOk ? ST_ADDR_ACK : ST_SKIP;
              ST_PTR:  state <= ST_PTR_ACK;
              default: state <= ST_DATA_ACK;
            endcase
          end
        end
        ST_ADDR_ACK: if (sclFall) state <= ST_PTR;
        ST_PTR_ACK, ST_DATA_ACK: if (sclFall) state <= ST_DATA;
        default: ;
      endcase
    end
  end

  assign sdaPullLow = (state == ST_ADDR_ACK) || (state == ST_PTR_ACK) || (state == ST_DATA_ACK);

  // R2: acknowledge is only ever asserted just after an SCL falling edge
  a_r2_ack_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> $past(sclFall));
  // R3: a rejected transfer never acknowledges
  a_r3_skip_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |=> !sdaPullLow);
  // R7: STOP returns to idle
  a_r7_stop_idle: assert property (@(posedge clk) disable iff (!rstN)
    (stopSeen && !startSeen) |=> (state == ST_IDLE));
endmodule

// File: rtl/cfg_i2c_regbank.sv
module cfg_i2c_regbank
  import cfg_i2c_pkg::*;
#(
  parameter int          REG_COUNT   = 4,
  parameter logic [6:0]  TARGET_ADDR = 7'b1110010
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sdaLevel,
  input  ctrlStrobe_t                   stb,
  output logic                          addrHit,
  output logic [REG_COUNT*BYTE_W-1:0]   regFlat,
  output logic [REG_COUNT-1:0]          regUpdated
);
  localparam int PTR_W = $clog2(REG_COUNT);
  localparam logic [PTR_W-1:0] LAST_REG = PTR_W'(REG_COUNT - 1);

  logic [BYTE_W-2:0] shiftReg;
  logic [BYTE_W-1:0] byteNow;
  logic [PTR_W-1:0]  ptr;

  assign byteNow = {shiftReg, sdaLevel};
  assign addrHit = (byteNow == {TARGET_ADDR, 1'b0});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      ptr      <= '0;
    end else begin
      if (stb.shiftEn) shiftReg <= byteNow[BYTE_W-2:0];
      if (stb.ptrLoad) ptr <= byteNow[PTR_W-1:0];
      else if (stb.commit) ptr <= (ptr == LAST_REG) ? '0 : ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : gReg
    logic hit;
    assign hit = stb.commit && (ptr == PTR_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regFlat[g*BYTE_W +: BYTE_W] <= '0;
        regUpdated[g]               <= 1'b0;
      end else begin
        regUpdated[g] <= hit;
        if (hit) regFlat[g*BYTE_W +: BYTE_W] <= byteNow;
      end
    end
  end

  // R10: at most one register strobe at a time, one cycle long
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(regUpdated));
  a_r10_short_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (|regUpdated) |=> !(|regUpdated));
  // R5: pointer wraps from the last register to register 0
  a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && ptr == LAST_REG) |=> (ptr == '0));
  // R7: without a commit strobe the bank holds its contents
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(regFlat));
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfg_i2c_pkg::*;
#(
  parameter int         REG_COUNT   = 4,
  parameter int         SYNC_DEPTH  = 2,
  parameter logic [6:0] TARGET_ADDR = 7'b1110010
) (
  input  logic                        clk,
  input  logic                        pwrGoodN,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  output logic                        sdaPullLow,
  output logic [REG_COUNT*BYTE_W-1:0] regBank,
  output logic [REG_COUNT-1:0]        regUpdated
);
  logic sdaLevel, sclRise, sclFall, startSeen, stopSeen, addrHit;
  ctrlStrobe_t stb;

  cfg_i2c_bus_sampler #(.SYNC_DEPTH(SYNC_DEPTH)) i_sampler (
    .clk(clk), .rstN(pwrGoodN), .sclRaw(sclIn), .sdaRaw(sdaIn),
    .sdaLevel(sdaLevel), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen));

  cfg_i2c_ctrl i_ctrl (
    .clk(clk), .rstN(pwrGoodN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .addrHit(addrHit),
    .stb(stb), .sdaPullLow(sdaPullLow));

  cfg_i2c_regbank #(.REG_COUNT(REG_COUNT), .TARGET_ADDR(TARGET_ADDR)) i_regbank (
    .clk(clk), .rstN(pwrGoodN), .sdaLevel(sdaLevel), .stb(stb),
    .addrHit(addrHit), .regFlat(regBank), .regUpdated(regUpdated));
endmodule

// File: tb/test_cfg_i2c_target.sv
module test_cfg_i2c_target;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic pwrGoodN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaPullLow;
  logic [31:0] regBank;
  logic [3:0] regUpdated;
  wire sdaLine = sdaM & ~sdaPullLow;

  always #5 clk = ~clk;

  cfg_i2c_target i_cfg_i2c_target (
    .clk(clk), .pwrGoodN(pwrGoodN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .regBank(regBank), .regUpdated(regUpdated));

  int tests = 0, fails = 0;
  int updCnt [4] = '{0, 0, 0, 0};
  int badStrobe = 0;
  logic [3:0] prevUpd = '0;
  logic [7:0] expRegs [4] = '{0, 0, 0, 0};
  logic [31:0] preSnap, postSnap;
  logic ackDuringD0;
  logic ack;

  always @(posedge clk) begin
    for (int i = 0; i < 4; i++) if (regUpdated[i]) updCnt[i]++;
    if ((regUpdated & prevUpd) != 0 || !$onehot0(regUpdated)) badStrobe++;
    prevUpd <= regUpdated;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expFlat();
    return {expRegs[3], expRegs[2], expRegs[1], expRegs[0]};
  endfunction

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2cStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic i2cStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic gotAck);
    for (int k = 7; k >= 0; k--) begin
      sdaM = b[k]; waitQ();
      if (k == 0) preSnap = regBank;
      sclM = 1'b1; waitQ();
      if (k == 0) begin postSnap = regBank; ackDuringD0 = sdaPullLow; end
      waitQ(); sclM = 1'b0; waitQ();
    end
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    gotAck = ~sdaLine;
    waitQ(); sclM = 1'b0; waitQ();
  endtask

  // {address byte, pointer byte, data byte, expected ack}
  localparam logic [24:0] VEC [7] = '{
    {8'hE4, 8'h00, 8'h5A, 1'b1},
    {8'hE4, 8'h01, 8'hA5, 1'b1},
    {8'hE4, 8'h02, 8'h3C, 1'b1},
    {8'hE4, 8'h03, 8'hC3, 1'b1},
    {8'hE5, 8'h00, 8'hFF, 1'b0},
    {8'hE6, 8'h01, 8'h00, 1'b0},
    {8'hE4, 8'h06, 8'h77, 1'b1}
  };

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 reset regBank", regBank, 32'h0);
    chk("R1 reset regUpdated", {28'h0, regUpdated}, 32'h0);
    chk("R1 reset sdaPullLow", {31'h0, sdaPullLow}, 32'h0);
    pwrGoodN = 1'b1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      logic [7:0] a, p, d;
      logic e;
      {a, p, d, e} = VEC[i];
      i2cStart();
      sendByte(a, ack); chk("R2/R3 address ack", {31'h0, ack}, {31'h0, e});
      sendByte(p, ack); chk("R4/R3 pointer ack", {31'h0, ack}, {31'h0, e});
      chk("R4 pointer byte writes nothing", regBank, expFlat());
      sendByte(d, ack); chk("R5/R3 data ack", {31'h0, ack}, {31'h0, e});
      i2cStop();
      if (e) expRegs[p[1:0]] = d;
      chk("R5/R3 bank after write", regBank, expFlat());
    end

    // R9, R5, R6, R10: long burst from register 2 wraps the pointer
    begin
      logic [7:0] burst [6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
      int cnt2;
      cnt2 = updCnt[2];
      i2cStart();
      sendByte(8'hE4, ack);
      sendByte(8'h02, ack);
      for (int j = 0; j < 6; j++) begin
        sendByte(burst[j], ack);
        chk("R9 every burst byte acked", {31'h0, ack}, 32'h1);
        if (j == 0) begin
          chk("R6 old value before D0 edge", preSnap, expFlat());
          expRegs[2] = 8'h11;
          chk("R6 new value after D0 edge", postSnap, expFlat());
          chk("R6 no ack yet at D0 edge", {31'h0, ackDuringD0}, 32'h0);
        end else expRegs[(2 + j) % 4] = burst[j];
      end
      i2cStop();
      chk("R5 wrap 3->0 contents", regBank, 32'h66554433);
      chk("R10 register 2 strobed twice", updCnt[2] - cnt2, 2);
      chk("R10 strobes single-cycle one-hot", badStrobe, 0);
    end

    // R7: bytes after STOP without START are ignored
    sclM = 1'b0; waitQ();
    sendByte(8'hE4, ack); chk("R7 no ack after STOP", {31'h0, ack}, 32'h0);
    sendByte(8'h00, ack);
    sendByte(8'hEE, ack);
    i2cStop();
    chk("R7 bank unchanged", regBank, expFlat());

    // R8: repeated START restarts address matching
    i2cStart();
    sendByte(8'hE4, ack);
    sendByte(8'h00, ack);
    sendByte(8'hAA, ack);
    expRegs[0] = 8'hAA;
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
    sendByte(8'hE5, ack); chk("R8 bad address after repeated START", {31'h0, ack}, 32'h0);
    sendByte(8'h01, ack); chk("R3 byte after NACK ignored", {31'h0, ack}, 32'h0);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
    sendByte(8'hE4, ack); chk("R8 good address after repeated START", {31'h0, ack}, 32'h1);
    sendByte(8'h01, ack);
    sendByte(8'hBB, ack);
    expRegs[1] = 8'hBB;
    i2cStop();
    chk("R8 bank after repeated START", regBank, expFlat());

    // R1: power-good drop clears the bank
    pwrGoodN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 bank cleared on power-good low", regBank, 32'h0);
    chk("R1 ack released on power-good low", {31'h0, sdaPullLow}, 32'h0);
    pwrGoodN = 1'b1;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule